// File: doc/BRIEF.md
# Quad Potentiometer SPI Command Front-End

This block is the serial command front-end of a four-channel digitally controlled potentiometer. It parses the framing that a host sends over SPI, decides whether a frame is meant for this device, and holds the register file. There are four 8-bit wiper position registers and sixteen 8-bit general data registers, four of them per wiper. The analog resistor ladder, non-volatile programming timing and wiper stepping are handled elsewhere. This block only supplies the register values and the serial access to them.

A frame starts when chip select goes low. The first byte is an identification byte. It is compared against a fixed device-type code and against an address that is partly strapped by two input pins. If the identification byte does not match, the rest of the frame is ignored. If it matches, an instruction byte follows, carrying an opcode, a data-register index and a wiper index. A data byte is then either written into the selected register or shifted out of it on SO. SO is driven only during that read byte, so SO may share a wire with SI.

All serial inputs are sampled by the system clock through one register stage, and SCK edges are detected from the sampled value. Each SCK high and low phase must therefore last at least two system clock cycles.

Top module: `qpot_spi_frontend`

## Requirements
- R1: After reset, every wiper register holds 0x80, every data register holds 0x00, and the SO enable is low.
- R2: SI is taken on rising SCK, most significant bit first. The first byte of a frame passes only if bits 7:4 are 0101. Any other device-type code makes the device ignore the rest of the frame: no register changes and SO stays undriven.
- R3: Bits 3:2 of the identification byte must be 00 and bits 1:0 must equal the levels on the address pins (addrPin[1] against bit 1). A mismatch makes the rest of the frame ignored, and the match follows the pins when they change.
- R4: In the instruction byte, bits 7:4 are the opcode, bits 3:2 select one of four data registers and bits 1:0 select the wiper. The data register addressed is number wiper*4 + select.
- R5: Opcode 1010 writes the following byte into the selected wiper register. Opcode 1100 writes it into the selected data register.
- R6: Opcode 1001 returns the selected wiper register and opcode 1011 returns the selected data register. The byte goes out on SO, MSB first, with each bit launched on a falling SCK edge so that it is valid at the next rising edge.
- R7: The SO enable is high only during the read data byte. It is low at all other times, including after the eighth read bit and whenever CS is high.
- R8: Any opcode other than the four listed leaves all registers unchanged and never enables SO.
- R9: A write takes effect only when all eight data bits have arrived. A frame closed after a partial data byte leaves the register unchanged.
- R10: CS going high aborts the frame at any point. The next frame starts again with an identification byte.
- R11: SCK edges seen while HOLD or WP is low are not counted and do not shift data.
- R12: A rising SCK edge sampled in the same cycle as CS high is discarded, so an abort takes precedence over the completion of a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| holdN | input | 1 | Active-low pause; SCK edges ignored while low |
| wpN | input | 1 | Active-low protect; SCK edges ignored while low |
| si | input | 1 | Serial data in |
| addrPin | input | 2 | Pin-strapped low address bits |
| so | output | 1 | Serial data out |
| soOe | output | 1 | Output enable for so (high = drive, low = high impedance) |

## Verification
Two functions can meet in the same system cycle: completing the eighth bit of a data byte, and aborting the frame because CS rises. The bench provokes this by raising SCK and CS on the same clock edge on the last bit of a wiper write. Both then reach the sampling register together. The bench then reads the wiper back through a normal frame and expects its old value, because the abort must win. A companion case raises CS after only five data bits, and a third case masks one SCK pulse with HOLD in the middle of a byte.

// File: rtl/qpot_pkg.sv
package qpot_pkg;
  localparam int DATA_W = 8;
  localparam int WSEL_W = 2;
  localparam int DSEL_W = 2;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_RD_WIPER = 4'b1001,
    OP_WR_WIPER = 4'b1010,
    OP_RD_DREG  = 4'b1011,
    OP_WR_DREG  = 4'b1100
  } opcode_e;

  typedef enum logic [2:0] {
    ST_ID, ST_INSTR, ST_WDATA, ST_READ, ST_SKIP
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              wrWiper;
    logic              wrDreg;
    logic              loadRd;
    logic              rdFromDreg;
    logic              shiftRd;
    logic [WSEL_W-1:0] wiperSel;
    logic [DSEL_W-1:0] dregSel;
    logic [DATA_W-1:0] wrData;
  } strobe_t;
endpackage

// File: rtl/qpot_ctrl.sv
module qpot_ctrl
  import qpot_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b0101
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sckIn,
  input  logic        csNIn,
  input  logic        holdNIn,
  input  logic        wpNIn,
  input  logic        siIn,
  input  logic [1:0]  addrPin,
  output strobe_t     strb,
  output logic        soOe
);
  localparam int CNT_W = $clog2(DATA_W);

  logic sckQ, sckQQ, csQ, siQ, enQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ <= 1'b0; sckQQ <= 1'b0; csQ <= 1'b1; siQ <= 1'b0; enQ <= 1'b0;
    end else begin
      sckQ <= sckIn; sckQQ <= sckQ; csQ <= csNIn; siQ <= siIn;
      enQ  <= holdNIn & wpNIn;
    end
  end

  // abort (csQ high) masks edges in the same cycle
  logic sckRise, sckFall;
  assign sckRise = sckQ & ~sckQQ & ~csQ & enQ;
  assign sckFall = ~sckQ & sckQQ & ~csQ & enQ;

  state_e             state;
  logic [CNT_W-1:0]   bitCnt;
  logic [DATA_W-2:0]  shiftQ;
  logic [OP_W-1:0]    opQ;
  logic [WSEL_W-1:0]  wSelQ;
  logic [DSEL_W-1:0]  dSelQ;

  logic [DATA_W-1:0] byteVal;
  logic              byteDone, idOk, isRead, isWrite;
  logic [OP_W-1:0]   newOp;
  assign byteVal  = {shiftQ, siQ};
  assign byteDone = sckRise && (bitCnt == CNT_W'(DATA_W-1));
  assign newOp    = byteVal[DATA_W-1 -: OP_W];
  assign idOk     = (newOp == DEV_TYPE) && (byteVal[3:2] == 2'b00) &&
                    (byteVal[1:0] == addrPin);
  assign isRead   = (newOp == OP_RD_WIPER) || (newOp == OP_RD_DREG);
  assign isWrite  = (newOp == OP_WR_WIPER) || (newOp == OP_WR_DREG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_ID; bitCnt <= '0; shiftQ <= '0; soOe <= 1'b0;
      opQ <= '0; wSelQ <= '0; dSelQ <= '0;
    end else if (csQ) begin
      state <= ST_ID; bitCnt <= '0; soOe <= 1'b0;
    end else begin
      if (sckFall && state == ST_READ) soOe <= 1'b1;
      if (sckRise) begin
        bitCnt <= bitCnt + CNT_W'(1);
        shiftQ <= byteVal[DATA_W-2:0];
      end
      if (byteDone) begin
        case (state)
          ST_ID:    state <= idOk ? ST_INSTR : ST_SKIP;
          ST_INSTR: begin
            opQ   <= newOp;
            dSelQ <= byteVal[WSEL_W +: DSEL_W];
            wSelQ <= byteVal[WSEL_W-1:0];
            state <= isRead ? ST_READ : (isWrite ? ST_WDATA : ST_SKIP);
          end
          ST_WDATA: state <= ST_SKIP;
          ST_READ:  begin state <= ST_SKIP; soOe <= 1'b0; end
          default:  state <= ST_SKIP;
        endcase
      end
    end
  end

  always_comb begin
    strb            = '0;
    strb.wrData     = byteVal;
    strb.wrWiper    = byteDone && state == ST_WDATA && opQ == OP_WR_WIPER;
    strb.wrDreg     = byteDone && state == ST_WDATA && opQ == OP_WR_DREG;
    strb.loadRd     = byteDone && state == ST_INSTR && isRead;
    strb.rdFromDreg = newOp == OP_RD_DREG;
    strb.shiftRd    = sckFall && state == ST_READ;
    if (state == ST_INSTR) begin
      strb.wiperSel = byteVal[WSEL_W-1:0];
      strb.dregSel  = byteVal[WSEL_W +: DSEL_W];
    end else begin
      strb.wiperSel = wSelQ;
      strb.dregSel  = dSelQ;
    end
  end

  // R7: a high chip select always releases SO
  p_cs_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    csQ |=> !soOe);
  // R5: at most one datapath action per cycle
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrWiper, strb.wrDreg, strb.loadRd, strb.shiftRd}));
  // R2: a foreign device type sends the frame to the skip state
  p_id_reject_r2: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && state == ST_ID && newOp != DEV_TYPE) |=> state == ST_SKIP);
  // R11: paused edges do not advance the bit counter
  p_hold_freeze_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!enQ && !csQ) |=> $stable(bitCnt));
endmodule

// File: rtl/qpot_regs.sv
module qpot_regs
  import qpot_pkg::*;
#(
  parameter logic [DATA_W-1:0] WIPER_RST = 8'h80,
  parameter logic [DATA_W-1:0] DREG_RST  = 8'h00
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  output logic    soData
);
  localparam int N_WIPERS = 1 << WSEL_W;
  localparam int N_DREGS  = N_WIPERS << DSEL_W;
  localparam int DIDX_W   = WSEL_W + DSEL_W;

  logic [DATA_W-1:0] wiperQ [N_WIPERS];
  logic [DATA_W-1:0] dregQ  [N_DREGS];
  logic [DIDX_W-1:0] dIdx;
  assign dIdx = {strb.wiperSel, strb.dregSel};

  for (genvar w = 0; w < N_WIPERS; w++) begin : g_wiper
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wiperQ[w] <= WIPER_RST;
      else if (strb.wrWiper && strb.wiperSel == WSEL_W'(w)) wiperQ[w] <= strb.wrData;
    end
    // R5 / R9: wiper changes exactly on its own completed write
    p_wiper_write_r5: assert property (@(posedge clk) disable iff (!rstN)
      (strb.wrWiper && strb.wiperSel == WSEL_W'(w)) |=> wiperQ[w] == $past(strb.wrData));
    p_wiper_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.wrWiper && strb.wiperSel == WSEL_W'(w)) |=> $stable(wiperQ[w]));
  end

  for (genvar d = 0; d < N_DREGS; d++) begin : g_dreg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dregQ[d] <= DREG_RST;
      else if (strb.wrDreg && dIdx == DIDX_W'(d)) dregQ[d] <= strb.wrData;
    end
    p_dreg_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.wrDreg && dIdx == DIDX_W'(d)) |=> $stable(dregQ[d]));
  end

  logic [DATA_W-1:0] rdShift;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdShift <= '0; soData <= 1'b0;
    end else if (strb.loadRd) begin
      rdShift <= strb.rdFromDreg ? dregQ[dIdx] : wiperQ[strb.wiperSel];
    end else if (strb.shiftRd) begin
      soData  <= rdShift[DATA_W-1];
      rdShift <= {rdShift[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/qpot_spi_frontend.sv
module qpot_spi_frontend
  import qpot_pkg::*;
#(
  parameter logic [3:0]        DEV_TYPE  = 4'b0101,
  parameter logic [DATA_W-1:0] WIPER_RST = 8'h80,
  parameter logic [DATA_W-1:0] DREG_RST  = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sck,
  input  logic       csN,
  input  logic       holdN,
  input  logic       wpN,
  input  logic       si,
  input  logic [1:0] addrPin,
  output logic       so,
  output logic       soOe
);
  strobe_t strb;

  qpot_ctrl #(.DEV_TYPE(DEV_TYPE)) ctrl_i (
    .clk(clk), .rstN(rstN), .sckIn(sck), .csNIn(csN), .holdNIn(holdN),
    .wpNIn(wpN), .siIn(si), .addrPin(addrPin), .strb(strb), .soOe(soOe)
  );

  qpot_regs #(.WIPER_RST(WIPER_RST), .DREG_RST(DREG_RST)) regs_i (
    .clk(clk), .rstN(rstN), .strb(strb), .soData(so)
  );
endmodule

// File: tb/qpot_spi_frontend_tb_top.sv
module qpot_spi_frontend_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sck = 1'b0, csN = 1'b1, holdN = 1'b1, wpN = 1'b1, si = 1'b0;
  logic [1:0] addrPin = 2'b01;
  logic so, soOe;

  always #4 clk = ~clk;

  qpot_spi_frontend dut_i (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .holdN(holdN), .wpN(wpN),
    .si(si), .addrPin(addrPin), .so(so), .soOe(soOe)
  );

  int total = 0, bad = 0;
  logic [7:0] wModel [4];
  logic [7:0] dModel [16];
  logic [7:0] expQ [$];
  string      tagQ [$];
  bit sawOe = 0;
  logic [7:0] rdAcc = '0;
  int rdCnt = 0;

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: collect SO bits at rising SCK and compare against the scoreboard
  always @(posedge sck) begin
    if (!csN && soOe) begin
      rdAcc = {rdAcc[6:0], so};
      rdCnt++;
      if (rdCnt == 8) begin
        rdCnt = 0;
        if (expQ.size() == 0) chk(0, "R6 unexpected read", rdAcc, 8'h00);
        else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(rdAcc === e, t, rdAcc, e);
        end
      end
    end
  end
  always @(posedge csN) rdCnt = 0;
  always @(posedge clk) if (soOe) sawOe = 1;

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic sckBit(input logic b);
    si = b;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask
  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sckBit(v[i]);
  endtask
  task automatic csLow();
    sawOe = 0;
    @(negedge clk); csN = 1'b0;
    repeat (4) @(negedge clk);
  endtask
  task automatic csHigh();
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (6) @(negedge clk);
  endtask
  function automatic bit idOk(input logic [7:0] id);
    return id[7:4] == 4'b0101 && id[3:2] == 2'b00 && id[1:0] == addrPin;
  endfunction

  // driver: full frame, updates model and scoreboard
  task automatic frame(input logic [7:0] id, input logic [7:0] op, input logic [7:0] data,
                       input string tag);
    bit ok;
    bit rd;
    ok = idOk(id);
    rd = ok && (op[7:4] == 4'b1001 || op[7:4] == 4'b1011);
    if (rd) begin
      expQ.push_back(op[7:4] == 4'b1001 ? wModel[op[1:0]] : dModel[{op[1:0], op[3:2]}]);
      tagQ.push_back(tag);
    end
    csLow();
    sendByte(id);
    sendByte(op);
    sendByte(data);
    repeat (4) @(negedge clk);
    chk(soOe == 1'b0, "R7 released after byte", {7'd0, soOe}, 8'h00);
    csHigh();
    if (!rd) chk(sawOe == 0, {tag, " no drive"}, {7'd0, sawOe}, 8'h00);
    if (ok && op[7:4] == 4'b1010) wModel[op[1:0]] = data;
    if (ok && op[7:4] == 4'b1100) dModel[{op[1:0], op[3:2]}] = data;
  endtask

  task automatic readAll(input string tag);
    for (int w = 0; w < 4; w++) frame({6'b010100, addrPin}, {4'b1001, 2'b00, 2'(w)}, 8'h00, tag);
    for (int d = 0; d < 16; d++) frame({6'b010100, addrPin}, {4'b1011, 2'(d % 4), 2'(d / 4)}, 8'h00, tag);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) wModel[i] = 8'h80;
    for (int i = 0; i < 16; i++) dModel[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(soOe == 1'b0, "R1 oe at reset", {7'd0, soOe}, 8'h00);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    readAll("R1 reset value");
    frame(8'h51, 8'hA2, 8'h3C, "R5 wiper write");
    frame(8'h51, 8'h92, 8'h00, "R6 wiper read");
    frame(8'h51, 8'hCD, 8'hA5, "R4 dreg write w1 d3");
    frame(8'h51, 8'hB7, 8'h00, "R4 dreg read w3 d1");
    frame(8'h51, 8'hBD, 8'h00, "R4 dreg read w1 d3");
    frame(8'h61, 8'hA0, 8'h11, "R2 bad type");
    frame(8'h59, 8'hA0, 8'h22, "R3 a3 set");
    frame(8'h52, 8'hA0, 8'h33, "R3 pin mismatch");
    frame(8'h51, 8'h70, 8'h44, "R8 unknown op");
    frame(8'h51, 8'hF3, 8'h45, "R8 unknown op");
    addrPin = 2'b10;
    frame(8'h52, 8'hA1, 8'h5A, "R3 new pins");
    frame(8'h51, 8'hA1, 8'h66, "R3 old address");
    frame(8'h52, 8'h91, 8'h00, "R3 readback");

    // R9: partial data byte then CS high
    csLow(); sendByte(8'h52); sendByte(8'hA0);
    for (int i = 0; i < 5; i++) sckBit(1'b1);
    csHigh();
    frame(8'h52, 8'h90, 8'h00, "R9 partial write");

    // R10: abort inside instruction, then a clean frame
    csLow(); sendByte(8'h52);
    for (int i = 0; i < 4; i++) sckBit(1'b1);
    csHigh();
    frame(8'h52, 8'hA3, 8'hC3, "R10 after abort");
    frame(8'h52, 8'h93, 8'h00, "R10 readback");

    // R11: a pulse under HOLD and one under WP are not counted
    csLow(); sendByte(8'h52); sendByte(8'hA0);
    for (int i = 7; i >= 0; i--) begin
      if (i == 4) begin holdN = 1'b0; sckBit(1'b0); holdN = 1'b1; end
      if (i == 2) begin wpN = 1'b0; sckBit(1'b1); wpN = 1'b1; end
      sckBit(8'h96 >> i);
    end
    csHigh();
    wModel[0] = 8'h96;
    frame(8'h52, 8'h90, 8'h00, "R11 masked pulses");

    // R12: eighth data bit rise coincides with CS rising
    csLow(); sendByte(8'h52); sendByte(8'hA0);
    for (int i = 7; i >= 1; i--) sckBit(8'h0F >> i);
    si = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b1; csN = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
    repeat (6) @(negedge clk);
    frame(8'h52, 8'h90, 8'h00, "R12 abort wins");

    readAll("R4 final sweep");
    chk(expQ.size() == 0, "R6 all reads seen", 8'(expQ.size()), 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule